// File: doc/BRIEF.md
# Ping-Pong Buffer Channel Tracker

This block keeps the bookkeeping for one DMA channel that owns two alternating hardware buffer descriptors, called halves. Software-side logic offers buffers through an enqueue stream. Each buffer size is checked against the channel's configured kind: control/async, isochronous or synchronous. An accepted buffer is assigned to the next half in turn, and the block emits an arm strobe carrying that half, its bit offset inside the descriptor word, and the encoded length. The DMA engine and memory access sit outside this block.

Completion runs in two stages, each with its own counter. In the hardware-acknowledge stage, a completion request is taken only when the done flag of the half currently being drained is set. The block then tells the descriptor logic to clear that half's done, error and ready bits, and the drain side moves to the other half. In the software-service stage, each service step consumes one acknowledged completion. It lowers the fill level and adds one to a count of finished buffers, which a consumer later detaches in batches.

The enqueue stream uses `enq_valid`/`enq_ready`. `enq_ready` is high while fewer than two buffers are outstanding. A beat is taken only on a cycle where both are high. A producer may hold `enq_valid` high while `enq_ready` is low and wait, but each such cycle is flagged as an overflow attempt. Every other pin is a plain control or status signal, and all error outputs are single-cycle pulses.

Top module: `pp_chan_tracker`

## Requirements
- R1: After reset, `fill_level` is 0, `enq_ready` is 1, `done_cnt` is 0, and `desc_arm`, `cmp_ack`, `err_ovf`, `err_size` and `err_udf` are all 0.
- R2: `enq_ready` is 1 exactly when `fill_level` is below 2. If `enq_valid` is high while `enq_ready` is low, `err_ovf` pulses on the next cycle, no arm strobe is produced, and the level is not raised.
- R3: A taken beat with a legal size produces, on the next cycle, `desc_arm`=1, `desc_half` equal to the fill index before the beat, `desc_bit_ofs` = 16 × `desc_half`, and `desc_len_m1` = size − 1. The fill index starts at 0 and flips on every accepted buffer, and the level rises by one.
- R4: A size of 0 is illegal for every kind. An illegal size on a taken beat pulses `err_size` on the next cycle, with no arm strobe and no change in level.
- R5: With `cfg_kind` = 0 (control/async), a size is legal when 1 ≤ size ≤ `CA_MAX`.
- R6: With `cfg_kind` = 1 (isochronous), a size is legal when `cfg_pkt_len` ≠ 0, size ≤ `IS_MAX`, size is an exact multiple of `cfg_pkt_len`, and size ≥ 2 × `cfg_pkt_len`.
- R7: With `cfg_kind` = 2 (synchronous), let unit = `cfg_bpf` << `cfg_fcnt`. A size is legal when unit ≠ 0, size ≤ `IS_MAX`, and size is a nonzero multiple of unit. With `cfg_kind` = 3, every size is illegal.
- R8: On a `cmp_req` cycle where `hw_done` bit [drain index] is 1, `cmp_ack` pulses next cycle, `cmp_half` equals that drain index, and the drain index flips; the drain index starts at 0. If that bit is 0, no acknowledge occurs and the drain index is kept, whatever the other bit holds.
- R9: A `svc_req` step counts only while the serviced count differs from the acknowledged count. A counted step with the level above 0 lowers the level by one and raises `done_cnt` by one. A counted step at level 0 pulses `err_udf` and changes neither the level nor `done_cnt`, but still counts as serviced. A `svc_req` with the counts equal has no effect.
- R10: `det_valid` with `det_num` ≤ `done_cnt` lowers `done_cnt` by `det_num`. A larger `det_num` pulses `err_udf` and leaves `done_cnt` unchanged.
- R11: A completion and a service request in the same cycle are handled in that order, so a buffer acknowledged in a cycle can be serviced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_kind | input | 2 | Channel kind: 0 control/async, 1 isochronous, 2 synchronous, 3 reserved |
| cfg_pkt_len | input | SIZE_W | Isochronous packet length |
| cfg_bpf | input | SIZE_W | Synchronous bytes per frame |
| cfg_fcnt | input | FCNT_W | Synchronous frame-count shift |
| enq_valid | input | 1 | Enqueue beat offered |
| enq_size | input | SIZE_W | Buffer size of the offered beat |
| enq_ready | output | 1 | Room for another buffer (level below 2) |
| desc_arm | output | 1 | One-cycle strobe: arm the indicated half |
| desc_half | output | 1 | Half being armed |
| desc_bit_ofs | output | 5 | Bit offset of that half within the descriptor word |
| desc_len_m1 | output | SIZE_W | Armed buffer size minus one |
| hw_done | input | 2 | Done flags of half 0 and half 1 |
| cmp_req | input | 1 | Completion (acknowledge) request |
| cmp_ack | output | 1 | One-cycle strobe: clear done/error/ready of `cmp_half` |
| cmp_half | output | 1 | Half being acknowledged |
| svc_req | input | 1 | Service step request |
| det_valid | input | 1 | Detach request |
| det_num | input | DONE_W | Number of finished buffers to detach |
| done_cnt | output | DONE_W | Finished buffers not yet detached |
| fill_level | output | 2 | Outstanding buffers, 0 to 2 |
| err_ovf | output | 1 | Overflow pulse |
| err_size | output | 1 | Illegal-size pulse |
| err_udf | output | 1 | Underflow pulse (service or detach) |

## Verification
The bench builds the tracker with an 8-bit size field, `CA_MAX` = 40, `IS_MAX` = 96, a 2-bit frame-count shift, 3-bit completion counters and a 4-bit done count. With these values, the size checker can be swept over every size for every packet length up to 15, and for every bytes-per-frame value up to 7 combined with every shift. Each verdict is compared against arithmetic computed in the bench, and each legal buffer exercises arm-half alternation and same-cycle acknowledge plus service. Short directed sequences then cover the full-level overflow, acknowledges masked by the wrong half's done flag, service on equal counts, service underflow after a spurious completion, and detach both within and beyond the done count.

// File: rtl/pp_tracker_pkg.sv
package pp_tracker_pkg;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_ISOC = 2'd1,
    KIND_SYNC = 2'd2,
    KIND_RSVD = 2'd3
  } chan_kind_e;

  localparam int unsigned HALVES      = 2;
  localparam int unsigned HALF_STRIDE = 16;
  localparam int unsigned OFS_W       = 5;

endpackage

// File: rtl/pp_size_check.sv
module pp_size_check
  import pp_tracker_pkg::*;
#(
  parameter int SIZE_W = 14,
  parameter int FCNT_W = 3,
  parameter int CA_MAX = 2048,
  parameter int IS_MAX = 8192
) (
  input  chan_kind_e          kind,
  input  logic [SIZE_W-1:0]   size,
  input  logic [SIZE_W-1:0]   pkt_len,
  input  logic [SIZE_W-1:0]   bpf,
  input  logic [FCNT_W-1:0]   fcnt,
  output logic                legal
);

  localparam int UNIT_W = SIZE_W + (1 << FCNT_W) - 1;
  localparam int WIDE_W = UNIT_W + 1;

  logic [WIDE_W-1:0] size_w;
  logic [WIDE_W-1:0] pkt_w;
  logic [WIDE_W-1:0] pkt_div;
  logic [WIDE_W-1:0] two_pkt;
  logic [WIDE_W-1:0] unit_w;
  logic [WIDE_W-1:0] unit_div;
  logic              nonzero;
  logic              ca_ok;
  logic              is_ok;
  logic              sy_ok;

  always_comb begin
    size_w   = WIDE_W'(size);
    pkt_w    = WIDE_W'(pkt_len);
    pkt_div  = (pkt_w == '0) ? WIDE_W'(1) : pkt_w;
    two_pkt  = pkt_w << 1;
    unit_w   = WIDE_W'(bpf) << fcnt;
    unit_div = (unit_w == '0) ? WIDE_W'(1) : unit_w;
    nonzero  = (size != '0);

    // control/async: bounded by the short descriptor length field
    ca_ok = nonzero && (size_w <= WIDE_W'(CA_MAX));

    // isochronous: whole packets, at least two of them
    is_ok = nonzero && (pkt_w != '0) && (size_w <= WIDE_W'(IS_MAX)) &&
            (size_w >= two_pkt) && ((size_w % pkt_div) == '0);

    // synchronous: whole frame groups, at least one of them
    sy_ok = nonzero && (unit_w != '0) && (size_w <= WIDE_W'(IS_MAX)) &&
            ((size_w % unit_div) == '0);

    unique case (kind)
      KIND_CTRL: legal = ca_ok;
      KIND_ISOC: legal = is_ok;
      KIND_SYNC: legal = sy_ok;
      default:   legal = 1'b0;
    endcase
  end

  // R4: zero-size buffer can never be legal
  always_comb begin
    if (size == '0) begin
      p_zero_size_r4: assert (!legal);
    end
  end

endmodule

// File: rtl/pp_ring_ctrl.sv
module pp_ring_ctrl
  import pp_tracker_pkg::*;
#(
  parameter int SIZE_W = 14,
  parameter int CNT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  input  logic [SIZE_W-1:0]  enq_size,
  input  logic               size_ok,
  input  logic               svc_dec,
  input  logic               cmp_req,
  input  logic [HALVES-1:0]  hw_done,
  output logic               enq_ready,
  output logic [1:0]         level,
  output logic               desc_arm,
  output logic               desc_half,
  output logic [OFS_W-1:0]   desc_bit_ofs,
  output logic [SIZE_W-1:0]  desc_len_m1,
  output logic               cmp_ack,
  output logic               cmp_half,
  output logic [CNT_W-1:0]   req_cnt_nxt,
  output logic               err_ovf,
  output logic               err_size
);

  logic             fill_idx;
  logic             drain_idx;
  logic [CNT_W-1:0] req_cnt;
  logic             take;
  logic             enq_acc;
  logic             cmp_acc;
  logic [1:0]       level_nxt;

  always_comb begin
    enq_ready   = (level < 2'd2);
    take        = enq_valid && enq_ready;
    enq_acc     = take && size_ok;
    cmp_acc     = cmp_req && hw_done[drain_idx];
    req_cnt_nxt = req_cnt + CNT_W'(cmp_acc);
    level_nxt   = level + 2'(enq_acc) - 2'(svc_dec);
  end

  assign desc_bit_ofs = OFS_W'(desc_half) * OFS_W'(HALF_STRIDE);

  // fill side: arm the next half on each accepted buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_idx    <= 1'b0;
      level       <= 2'd0;
      desc_arm    <= 1'b0;
      desc_half   <= 1'b0;
      desc_len_m1 <= '0;
      err_ovf     <= 1'b0;
      err_size    <= 1'b0;
    end else begin
      level    <= level_nxt;
      desc_arm <= enq_acc;
      err_ovf  <= enq_valid && !enq_ready;
      err_size <= take && !size_ok;
      if (enq_acc) begin
        desc_half   <= fill_idx;
        desc_len_m1 <= enq_size - SIZE_W'(1);
        fill_idx    <= ~fill_idx;
      end
    end
  end

  // drain side: acknowledge the half whose done flag is up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_idx <= 1'b0;
      req_cnt   <= '0;
      cmp_ack   <= 1'b0;
      cmp_half  <= 1'b0;
    end else begin
      cmp_ack <= cmp_acc;
      req_cnt <= req_cnt_nxt;
      if (cmp_acc) begin
        cmp_half  <= drain_idx;
        drain_idx <= ~drain_idx;
      end
    end
  end

  p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 2'd2);

  p_ovf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready && !svc_dec) |=> (level == $past(level)) && !desc_arm);

  p_fill_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && size_ok) |=> (fill_idx != $past(fill_idx)) && desc_arm);

  p_arm_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_arm |-> $past(enq_ready));

  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !hw_done[drain_idx]) |=> !cmp_ack && (drain_idx == $past(drain_idx)));

endmodule

// File: rtl/pp_svc_count.sv
module pp_svc_count #(
  parameter int CNT_W  = 4,
  parameter int DONE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_req,
  input  logic [CNT_W-1:0]  req_cnt_nxt,
  input  logic [1:0]        level,
  input  logic              det_valid,
  input  logic [DONE_W-1:0] det_num,
  output logic              svc_dec,
  output logic [DONE_W-1:0] done_cnt,
  output logic              err_udf
);

  logic [CNT_W-1:0]  svc_cnt;
  logic              svc_try;
  logic              svc_udf;
  logic              det_ok;
  logic              det_udf;
  logic [DONE_W-1:0] done_nxt;

  always_comb begin
    // compared against the count including this cycle's acknowledge
    svc_try  = svc_req && (svc_cnt != req_cnt_nxt);
    svc_dec  = svc_try && (level != 2'd0);
    svc_udf  = svc_try && (level == 2'd0);
    det_ok   = det_valid && (det_num <= done_cnt);
    det_udf  = det_valid && !det_ok;
    done_nxt = done_cnt + DONE_W'(svc_dec) - (det_ok ? det_num : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_cnt  <= '0;
      done_cnt <= '0;
      err_udf  <= 1'b0;
    end else begin
      if (svc_try) svc_cnt <= svc_cnt + CNT_W'(1);
      done_cnt <= done_nxt;
      err_udf  <= svc_udf || det_udf;
    end
  end

  p_level_zero_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd0 && !det_valid) |=> done_cnt == $past(done_cnt));

  p_det_over_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_num > done_cnt && !svc_dec) |=> (done_cnt == $past(done_cnt)) && err_udf);

endmodule

// File: rtl/pp_chan_tracker.sv
module pp_chan_tracker
  import pp_tracker_pkg::*;
#(
  parameter int SIZE_W = 14,
  parameter int FCNT_W = 3,
  parameter int CA_MAX = 2048,
  parameter int IS_MAX = 8192,
  parameter int CNT_W  = 4,
  parameter int DONE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_kind,
  input  logic [SIZE_W-1:0] cfg_pkt_len,
  input  logic [SIZE_W-1:0] cfg_bpf,
  input  logic [FCNT_W-1:0] cfg_fcnt,
  input  logic              enq_valid,
  input  logic [SIZE_W-1:0] enq_size,
  output logic              enq_ready,
  output logic              desc_arm,
  output logic              desc_half,
  output logic [4:0]        desc_bit_ofs,
  output logic [SIZE_W-1:0] desc_len_m1,
  input  logic [1:0]        hw_done,
  input  logic              cmp_req,
  output logic              cmp_ack,
  output logic              cmp_half,
  input  logic              svc_req,
  input  logic              det_valid,
  input  logic [DONE_W-1:0] det_num,
  output logic [DONE_W-1:0] done_cnt,
  output logic [1:0]        fill_level,
  output logic              err_ovf,
  output logic              err_size,
  output logic              err_udf
);

  logic             size_ok;
  logic             svc_dec;
  logic [CNT_W-1:0] req_cnt_nxt;
  logic             udf_pulse;

  pp_size_check #(
    .SIZE_W(SIZE_W), .FCNT_W(FCNT_W), .CA_MAX(CA_MAX), .IS_MAX(IS_MAX)
  ) u_size (
    .kind    (chan_kind_e'(cfg_kind)),
    .size    (enq_size),
    .pkt_len (cfg_pkt_len),
    .bpf     (cfg_bpf),
    .fcnt    (cfg_fcnt),
    .legal   (size_ok)
  );

  pp_ring_ctrl #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_valid    (enq_valid),
    .enq_size     (enq_size),
    .size_ok      (size_ok),
    .svc_dec      (svc_dec),
    .cmp_req      (cmp_req),
    .hw_done      (hw_done),
    .enq_ready    (enq_ready),
    .level        (fill_level),
    .desc_arm     (desc_arm),
    .desc_half    (desc_half),
    .desc_bit_ofs (desc_bit_ofs),
    .desc_len_m1  (desc_len_m1),
    .cmp_ack      (cmp_ack),
    .cmp_half     (cmp_half),
    .req_cnt_nxt  (req_cnt_nxt),
    .err_ovf      (err_ovf),
    .err_size     (err_size)
  );

  pp_svc_count #(
    .CNT_W(CNT_W), .DONE_W(DONE_W)
  ) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .svc_req     (svc_req),
    .req_cnt_nxt (req_cnt_nxt),
    .level       (fill_level),
    .det_valid   (det_valid),
    .det_num     (det_num),
    .svc_dec     (svc_dec),
    .done_cnt    (done_cnt),
    .err_udf     (udf_pulse)
  );

  assign err_udf = udf_pulse;

  // R11: acknowledge and service in one cycle drain a single buffer fully
  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == 2'd1 && cmp_req && hw_done == 2'b11 && svc_req && !enq_valid)
      |=> cmp_ack && (fill_level == 2'd0));

endmodule

// File: tb/pp_chan_tracker_tb_top.sv
module pp_chan_tracker_tb_top;

  localparam int SIZE_W = 8;
  localparam int FCNT_W = 2;
  localparam int CA_MAX = 40;
  localparam int IS_MAX = 96;
  localparam int CNT_W  = 3;
  localparam int DONE_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_kind = '0;
  logic [SIZE_W-1:0] cfg_pkt_len = '0;
  logic [SIZE_W-1:0] cfg_bpf = '0;
  logic [FCNT_W-1:0] cfg_fcnt = '0;
  logic              enq_valid = 1'b0;
  logic [SIZE_W-1:0] enq_size = '0;
  logic              enq_ready;
  logic              desc_arm;
  logic              desc_half;
  logic [4:0]        desc_bit_ofs;
  logic [SIZE_W-1:0] desc_len_m1;
  logic [1:0]        hw_done = '0;
  logic              cmp_req = 1'b0;
  logic              cmp_ack;
  logic              cmp_half;
  logic              svc_req = 1'b0;
  logic              det_valid = 1'b0;
  logic [DONE_W-1:0] det_num = '0;
  logic [DONE_W-1:0] done_cnt;
  logic [1:0]        fill_level;
  logic              err_ovf;
  logic              err_size;
  logic              err_udf;

  int n_chk  = 0;
  int n_fail = 0;
  int efill  = 0;
  int edrain = 0;
  int edone  = 0;

  always #2 clk = ~clk;

  pp_chan_tracker #(
    .SIZE_W(SIZE_W), .FCNT_W(FCNT_W), .CA_MAX(CA_MAX), .IS_MAX(IS_MAX),
    .CNT_W(CNT_W), .DONE_W(DONE_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_pkt_len(cfg_pkt_len),
    .cfg_bpf(cfg_bpf), .cfg_fcnt(cfg_fcnt), .enq_valid(enq_valid),
    .enq_size(enq_size), .enq_ready(enq_ready), .desc_arm(desc_arm),
    .desc_half(desc_half), .desc_bit_ofs(desc_bit_ofs), .desc_len_m1(desc_len_m1),
    .hw_done(hw_done), .cmp_req(cmp_req), .cmp_ack(cmp_ack), .cmp_half(cmp_half),
    .svc_req(svc_req), .det_valid(det_valid), .det_num(det_num),
    .done_cnt(done_cnt), .fill_level(fill_level), .err_ovf(err_ovf),
    .err_size(err_size), .err_udf(err_udf)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_legal(int kind, int size, int pkt, int bpf, int fc);
    int unit;
    if (size == 0) return 1'b0;
    case (kind)
      0: return size <= CA_MAX;
      1: return (pkt != 0) && (size <= IS_MAX) && (size >= 2 * pkt) && (size % pkt == 0);
      2: begin
        unit = bpf << fc;
        return (unit != 0) && (size <= IS_MAX) && (size % unit == 0);
      end
      default: return 1'b0;
    endcase
  endfunction

  // one enqueue; a legal one is drained by a same-cycle acknowledge + service
  task automatic try_one(input int kind, input int size, input int pkt, input int bpf, input int fc,
                         input string tag);
    bit lg;
    lg          = exp_legal(kind, size, pkt, bpf, fc);
    cfg_kind    = 2'(kind);
    cfg_pkt_len = SIZE_W'(pkt);
    cfg_bpf     = SIZE_W'(bpf);
    cfg_fcnt    = FCNT_W'(fc);
    enq_size    = SIZE_W'(size);
    enq_valid   = 1'b1;
    cyc();
    enq_valid = 1'b0;
    if (lg) begin
      chk({tag, " R3 arm/err/half/ofs"},
          {desc_arm, err_size, desc_half, 32'(desc_bit_ofs)} , {1'b1, 1'b0, 1'(efill), 32'(efill * 16)});
      chk({tag, " R3 len"}, int'(desc_len_m1), size - 1);
      cmp_req = 1'b1; hw_done = 2'b11; svc_req = 1'b1;
      cyc();
      cmp_req = 1'b0; hw_done = 2'b00; svc_req = 1'b0;
      chk("R11 ack+half", {cmp_ack, cmp_half}, {1'b1, 1'(edrain)});
      chk("R11 level", int'(fill_level), 0);
      efill  ^= 1;
      edrain ^= 1;
      edone   = (edone + 1) % 16;
    end else begin
      chk({tag, (size == 0) ? " R4 zero" : " R4 reject"}, {desc_arm, err_size}, {1'b0, 1'b1});
      chk({tag, " R4 level"}, int'(fill_level), 0);
    end
  endtask

  task automatic enq_ctrl(input int size);
    cfg_kind = 2'd0; enq_size = SIZE_W'(size); enq_valid = 1'b1;
    cyc();
    enq_valid = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 level", int'(fill_level), 0);
    chk("R1 ready", int'(enq_ready), 1);
    chk("R1 done_cnt", int'(done_cnt), 0);
    chk("R1 strobes", {desc_arm, cmp_ack, err_ovf, err_size, err_udf}, 0);

    for (int s = 0; s < 256; s++) try_one(0, s, 0, 0, 0, "R5");
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 256; s++) try_one(1, s, p, 0, 0, "R6");
    for (int b = 0; b < 8; b++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 256; s++) try_one(2, s, 0, b, f, "R7");
    for (int s = 0; s < 256; s += 5) try_one(3, s, 3, 1, 0, "R7 rsvd");

    // R2: fill both halves, then overflow
    enq_ctrl(8);
    chk("R2 level one", int'(fill_level), 1);
    chk("R3 alternate a", int'(desc_half), efill);
    efill ^= 1;
    enq_ctrl(9);
    chk("R3 alternate b", int'(desc_half), efill);
    efill ^= 1;
    chk("R2 level two", int'(fill_level), 2);
    chk("R2 not ready", int'(enq_ready), 0);
    enq_ctrl(4);
    chk("R2 overflow", {err_ovf, desc_arm}, {1'b1, 1'b0});
    chk("R2 level held", int'(fill_level), 2);

    // R8: acknowledge gated by the drain half's done flag only
    cmp_req = 1'b1; hw_done = 2'b00;
    cyc();
    chk("R8 no done", int'(cmp_ack), 0);
    hw_done = 2'(1 << (1 - edrain));
    cyc();
    chk("R8 wrong half", int'(cmp_ack), 0);
    hw_done = 2'(1 << edrain);
    cyc();
    cmp_req = 1'b0; hw_done = 2'b00;
    chk("R8 ack", {cmp_ack, cmp_half}, {1'b1, 1'(edrain)});
    edrain ^= 1;

    // R9: service one, then service with equal counts
    svc_req = 1'b1;
    cyc();
    chk("R9 level down", int'(fill_level), 1);
    edone = (edone + 1) % 16;
    chk("R9 done up", int'(done_cnt), edone);
    cyc();
    svc_req = 1'b0;
    chk("R9 equal counts level", int'(fill_level), 1);
    chk("R9 equal counts done/udf", {28'(done_cnt), err_udf}, {28'(edone), 1'b0});

    // R11 again on second buffer
    cmp_req = 1'b1; hw_done = 2'b11; svc_req = 1'b1;
    cyc();
    cmp_req = 1'b0; hw_done = 2'b00; svc_req = 1'b0;
    chk("R11 second half", {cmp_ack, cmp_half}, {1'b1, 1'(edrain)});
    chk("R11 level zero", int'(fill_level), 0);
    edrain ^= 1;
    edone = (edone + 1) % 16;

    // R9: spurious completion then service at level zero
    cmp_req = 1'b1; hw_done = 2'b11;
    cyc();
    cmp_req = 1'b0; hw_done = 2'b00;
    chk("R8 spurious ack", int'(cmp_ack), 1);
    edrain ^= 1;
    svc_req = 1'b1;
    cyc();
    chk("R9 underflow", int'(err_udf), 1);
    chk("R9 underflow level/done", {28'(done_cnt), fill_level}, {28'(edone), 2'd0});
    cyc();
    svc_req = 1'b0;
    chk("R9 counted after underflow", int'(err_udf), 0);

    // R10: detach exact count, then one too many
    det_valid = 1'b1; det_num = DONE_W'(edone);
    cyc();
    chk("R10 detach all", {int'(done_cnt), int'(err_udf)}, 0);
    det_num = DONE_W'(1);
    cyc();
    det_valid = 1'b0;
    chk("R10 over detach", {28'(done_cnt), err_udf}, {28'd0, 1'b1});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule